// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a bit-serial EEPROM of 128 bytes through four wires: a chip select, a serial clock, a data line towards the device and a data line back from it. A host gives one command at a time: byte read, byte write, byte erase, erase of the whole array, write of one value to the whole array, and the two commands that unlock or lock programming. The block turns the command into a 10-bit frame (a start bit, a 2-bit opcode, a 7-bit address), adds a data byte where the command carries one, collects the returned byte for reads and reports a 2-bit completion code with a one-cycle done pulse.

Every command that programs the array (write, erase, erase-all, write-all) ends with a completion handshake. Chip select is dropped, raised again, and the returned data line is watched. The device must show busy (low) first and then ready (high). A device that never shows busy gives code 1. A device that stays busy through the whole poll budget gives code 2. The serial clock comes from a divider of the system clock. The poll interval and the poll budget are parameters.

The controller is one state machine. Its states are IDLE (waiting for start), SEND (frame and data bits out), RECV (8 read bits in), GAP (chip select low after a programming frame), CHK1 and CHK2 (first and second busy samples), POLL (spaced ready samples), FIN (one cycle that gives done and latches results) and HOLD (chip select held low before the next command). The transitions are:
- IDLE to SEND on start.
- SEND to RECV for a read, to GAP for a programming command, and to FIN for unlock or lock.
- RECV to FIN after 8 bits.
- GAP to CHK1.
- CHK1 to POLL when the line is low, and to CHK2 when it is high.
- CHK2 to POLL when the line is low, and to FIN with code 1 when it is high.
- POLL to FIN with code 0 on ready, and with code 2 when the budget runs out.
- FIN to HOLD, and HOLD to IDLE.

Top module: `sereeprom_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `busy` and `done` are all 0.
- R2: Each frame sends a 1 first, then the opcode, then the 7-bit address MSB first. The opcode is 10 for read, 01 for write, 11 for erase and 00 for special commands, with the left bit sent first. A special command is picked by the two address bits sent first: 11 unlocks, 00 locks, 10 erases all, 01 writes all. The other five address bits are sent as 0. The `cmd` codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 unlock, 6 lock, and 7 acts as lock.
- R3: A read shifts in 8 bits MSB first, right after the address. Each bit is sampled on a rising `ee_sk`. The byte is presented on `rdata` with `done`, with `status` 0.
- R4: A write sends the data byte MSB first, right after the address. It then runs the completion handshake. It finishes with `status` 0 when busy was seen and ready followed.
- R5: Erase, erase-all and write-all use the same handshake. Write-all also carries the data byte.
- R6: If `ee_di` reads high on both busy samples after chip select is raised again, the command finishes with `status` 1.
- R7: Ready is sampled every `POLL_TICKS` divider ticks. If `POLL_LIMIT` samples pass without ready, the command finishes with `status` 2. Code 3 is never reported.
- R8: A `start` while `busy` is high is ignored. This includes the cycle in which `done` is high. `ee_cs` is low whenever `busy` is low.
- R9: `ee_cs` falls at the end of every command, including unlock and lock. It stays low for at least 2*`CLK_DIV` clock cycles before it rises again.
- R10: `ee_sk` is low whenever `ee_cs` is low. `ee_do` changes only while `ee_sk` is low. Rising `ee_sk` edges within a command are 2*`CLK_DIV` cycles apart.
- R11: `busy` rises in the cycle after an accepted `start`. `done` is a single-cycle pulse given while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, taken only when idle |
| cmd | input | 3 | Command code (see R2) |
| addr | input | 7 | Byte address |
| wdata | input | 8 | Byte for write or write-all |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read (valid with done after a read) |
| status | output | 2 | 0 ok, 1 never busy, 2 ready timeout |
| ee_cs | output | 1 | Chip select to the device |
| ee_sk | output | 1 | Serial clock to the device |
| ee_do | output | 1 | Serial data to the device |
| ee_di | input | 1 | Serial data and ready/busy from the device |

## Verification
A new `start` can arrive in the same cycle as a command's `done` pulse. That cycle is where the host sees a result and wants to issue the next command, so acceptance and completion meet there. The bench provokes this by raising `start` with a different write in exactly the cycle it sees `done`, and again with a write-all a few cycles into a running command. It then judges the outcome at the ports: the count of frames the device model received must grow by exactly one, and reading back the cells the stray commands would have changed must return their old values.

// File: rtl/swire_pkg.sv
package swire_pkg;

    localparam int CMD_W   = 3;
    localparam int OP_W    = 2;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int STAT_W  = 2;
    localparam int FRAME_W = 1 + OP_W + ADDR_W;

    localparam logic [CMD_W-1:0] CMD_READ      = 3'd0;
    localparam logic [CMD_W-1:0] CMD_WRITE     = 3'd1;
    localparam logic [CMD_W-1:0] CMD_ERASE     = 3'd2;
    localparam logic [CMD_W-1:0] CMD_ERASE_ALL = 3'd3;
    localparam logic [CMD_W-1:0] CMD_WRITE_ALL = 3'd4;
    localparam logic [CMD_W-1:0] CMD_UNLOCK    = 3'd5;
    localparam logic [CMD_W-1:0] CMD_LOCK      = 3'd6;

    localparam logic [STAT_W-1:0] STAT_OK      = 2'd0;
    localparam logic [STAT_W-1:0] STAT_NO_BUSY = 2'd1;
    localparam logic [STAT_W-1:0] STAT_TIMEOUT = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SEND, ST_RECV, ST_GAP, ST_CHK1,
        ST_CHK2, ST_POLL, ST_FIN, ST_HOLD
    } state_e;

    function automatic logic [FRAME_W-1:0] frame_word(
        input logic [CMD_W-1:0]  c,
        input logic [ADDR_W-1:0] a
    );
        logic [OP_W+ADDR_W-1:0] body;
        case (c)
            CMD_READ:      body = {2'b10, a};
            CMD_WRITE:     body = {2'b01, a};
            CMD_ERASE:     body = {2'b11, a};
            CMD_ERASE_ALL: body = {2'b00, 2'b10, {(ADDR_W-2){1'b0}}};
            CMD_WRITE_ALL: body = {2'b00, 2'b01, {(ADDR_W-2){1'b0}}};
            CMD_UNLOCK:    body = {2'b00, 2'b11, {(ADDR_W-2){1'b0}}};
            default:       body = {2'b00, 2'b00, {(ADDR_W-2){1'b0}}};
        endcase
        return {1'b1, body};
    endfunction

    function automatic logic carries_data(input logic [CMD_W-1:0] c);
        return (c == CMD_WRITE) || (c == CMD_WRITE_ALL);
    endfunction

    function automatic logic programs(input logic [CMD_W-1:0] c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) ||
               (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
    endfunction

endpackage

// File: rtl/swire_tick.sv
module swire_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (!run)                    cnt <= '0;
        else if (cnt == CW'(DIV - 1))     cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/swire_shift.sv
module swire_shift #(
    parameter int TX_W = 18,
    parameter int RX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            shift,
    input  logic            capture,
    input  logic            sin,
    output logic            sout,
    output logic [RX_W-1:0] rx
);
    logic [TX_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx   <= '0;
        end else begin
            if (load)       tx_q <= load_val;
            else if (shift) tx_q <= {tx_q[TX_W-2:0], 1'b0};
            if (load)          rx <= '0;
            else if (capture)  rx <= {rx[RX_W-2:0], sin};
        end
    end

    assign sout = tx_q[TX_W-1];
endmodule

// File: rtl/swire_poll.sv
module swire_poll #(
    parameter int INTERVAL = 64,
    parameter int LIMIT    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic due,
    output logic last
);
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int PW = $clog2(LIMIT + 1);

    logic [IW-1:0] ival;
    logic [PW-1:0] polls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ival  <= '0;
            polls <= '0;
        end else if (clr) begin
            ival  <= '0;
            polls <= '0;
        end else if (tick) begin
            if (ival == IW'(INTERVAL - 1)) begin
                ival <= '0;
                if (polls != PW'(LIMIT)) polls <= polls + 1'b1;
            end else begin
                ival <= ival + 1'b1;
            end
        end
    end

    assign due  = tick && (ival == IW'(INTERVAL - 1));
    assign last = (polls == PW'(LIMIT - 1));
endmodule

// File: rtl/sereeprom_master.sv
module sereeprom_master
    import swire_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int POLL_TICKS = 64,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [STAT_W-1:0] status,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_do,
    input  logic              ee_di
);
    localparam int TX_W  = FRAME_W + DATA_W;
    localparam int BIT_W = $clog2(TX_W);

    state_e              state, nxt;
    logic                ph;
    logic [BIT_W-1:0]    bitcnt;
    logic [CMD_W-1:0]    op_q;
    logic [STAT_W-1:0]   stat_q, fin_stat;
    logic [DATA_W-1:0]   rdata_q;
    logic [BIT_W-1:0]    last_idx;
    logic                run, tick, ld, sh, cap, pclr, due, last, so;
    logic [DATA_W-1:0]   rx;

    assign run      = (state != ST_IDLE) && (state != ST_FIN);
    assign last_idx = carries_data(op_q) ? BIT_W'(TX_W - 1) : BIT_W'(FRAME_W - 1);

    swire_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    swire_shift #(.TX_W(TX_W), .RX_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ld),
        .load_val({frame_word(cmd, addr), wdata}),
        .shift(sh), .capture(cap), .sin(ee_di),
        .sout(so), .rx(rx)
    );

    swire_poll #(.INTERVAL(POLL_TICKS), .LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(pclr), .tick(tick),
        .due(due), .last(last)
    );

    // next state and datapath strobes
    always_comb begin
        nxt      = state;
        ld       = 1'b0;
        sh       = 1'b0;
        cap      = 1'b0;
        pclr     = (state != ST_POLL);
        fin_stat = STAT_OK;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt = ST_SEND;
                    ld  = 1'b1;
                end
            end
            ST_SEND: begin
                if (tick && ph) begin
                    if (bitcnt == last_idx) begin
                        if (op_q == CMD_READ)  nxt = ST_RECV;
                        else if (programs(op_q)) nxt = ST_GAP;
                        else                   nxt = ST_FIN;
                    end else begin
                        sh = 1'b1;
                    end
                end
            end
            ST_RECV: begin
                cap = tick && !ph;
                if (tick && ph && bitcnt == BIT_W'(DATA_W - 1)) nxt = ST_FIN;
            end
            ST_GAP: begin
                if (tick && ph) nxt = ST_CHK1;
            end
            ST_CHK1: begin
                if (tick) nxt = ee_di ? ST_CHK2 : ST_POLL;
            end
            ST_CHK2: begin
                if (tick) begin
                    if (ee_di) begin
                        nxt      = ST_FIN;
                        fin_stat = STAT_NO_BUSY;
                    end else begin
                        nxt = ST_POLL;
                    end
                end
            end
            ST_POLL: begin
                if (due) begin
                    if (ee_di) begin
                        nxt = ST_FIN;
                    end else if (last) begin
                        nxt      = ST_FIN;
                        fin_stat = STAT_TIMEOUT;
                    end
                end
            end
            ST_FIN: begin
                nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (tick && ph) nxt = ST_IDLE;
            end
        endcase
    end

    // state register with phase, bit count and result latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ph      <= 1'b0;
            bitcnt  <= '0;
            op_q    <= CMD_READ;
            stat_q  <= STAT_OK;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (state != nxt) begin
                ph     <= 1'b0;
                bitcnt <= '0;
            end else if (tick) begin
                ph <= ~ph;
                if (ph) bitcnt <= bitcnt + 1'b1;
            end
            if (state == ST_IDLE && start) op_q <= cmd;
            if (nxt == ST_FIN && state != ST_FIN) begin
                stat_q  <= fin_stat;
                rdata_q <= (op_q == CMD_READ) ? rx : '0;
            end
        end
    end

    // outputs
    always_comb begin
        busy   = (state != ST_IDLE);
        done   = (state == ST_FIN);
        rdata  = rdata_q;
        status = stat_q;
        ee_cs  = (state == ST_SEND) || (state == ST_RECV) || (state == ST_CHK1) ||
                 (state == ST_CHK2) || (state == ST_POLL);
        ee_sk  = ((state == ST_SEND) || (state == ST_RECV)) && ph;
        ee_do  = (state == ST_SEND) && so;
    end
endmodule

// File: rtl/swire_chk.sv
module swire_chk #(
    parameter int CLK_DIV = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       ee_cs,
    input logic       ee_sk,
    input logic       ee_do
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_run <= 16'hFFFF;
        else if (ee_cs)            low_run <= '0;
        else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
    end

    assert_sk_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    assert_do_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_do));

    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (low_run >= 16'(2 * CLK_DIV)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_cs);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_status_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3));
endmodule

bind sereeprom_master swire_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do)
);

// File: tb/sim_sereeprom_master.sv
`timescale 1ns/1ps
module sim_sereeprom_master;
    localparam int DIV   = 2;
    localparam int PT    = 4;
    localparam int PL    = 8;
    localparam int BUSYC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [6:0] addr = 7'd0;
    logic [7:0] wdata = 8'd0;
    logic       busy, done, ee_cs, ee_sk, ee_do, ee_di;
    logic [7:0] rdata;
    logic [1:0] status;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    sereeprom_master #(.CLK_DIV(DIV), .POLL_TICKS(PT), .POLL_LIMIT(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .status(status),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
    );

    // ---------------- device model ----------------
    logic [7:0] mem [128];
    logic [17:0] sr = '0;
    logic [9:0]  last_frame = '0;
    int   nb = 0;
    bit   wen = 0;
    bit   rd_on = 0;
    int   rd_i = 0;
    logic [6:0] rd_a = '0;
    logic do_bit = 1'b1;
    int   busy_cnt = 0;
    bit   stuck = 0;
    int   nframes = 0;

    initial for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'hA5;

    assign ee_di = rd_on ? do_bit : (busy_cnt != 0 ? 1'b0 : 1'b1);

    always @(posedge ee_sk) if (ee_cs && !rd_on) begin
        sr = {sr[16:0], ee_do};
        nb++;
        if (nb == 10) begin
            last_frame = sr[9:0];
            if (sr[8:7] == 2'b10) begin
                rd_on = 1; rd_a = sr[6:0]; rd_i = 0;
            end
        end
    end

    always @(negedge ee_sk) if (ee_cs && rd_on && rd_i < 8) begin
        do_bit = mem[rd_a][7 - rd_i];
        rd_i++;
    end

    always @(negedge ee_cs) begin
        if (nb >= 10) begin
            nframes++;
            case (last_frame[8:7])
                2'b01: if (nb == 18 && wen) begin mem[last_frame[6:0]] = sr[7:0]; busy_cnt = BUSYC; end
                2'b11: if (wen) begin mem[last_frame[6:0]] = 8'hFF; busy_cnt = BUSYC; end
                2'b00: case (last_frame[6:5])
                    2'b11: wen = 1;
                    2'b00: wen = 0;
                    2'b10: if (wen) begin for (int i = 0; i < 128; i++) mem[i] = 8'hFF; busy_cnt = BUSYC; end
                    default: if (wen && nb == 18) begin for (int i = 0; i < 128; i++) mem[i] = sr[7:0]; busy_cnt = BUSYC; end
                endcase
                default: ;
            endcase
        end
        nb = 0; rd_on = 0; do_bit = 1'b1;
    end

    always @(posedge clk) if (!stuck && busy_cnt > 0) busy_cnt--;

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_frame(input int c, input int a);
        case (c)
            0: return 10'h200 | (10'd2 << 7) | 10'(a);
            1: return 10'h200 | (10'd1 << 7) | 10'(a);
            2: return 10'h200 | (10'd3 << 7) | 10'(a);
            3: return 10'h200 | (10'd2 << 5);
            4: return 10'h200 | (10'd1 << 5);
            5: return 10'h200 | (10'd3 << 5);
            default: return 10'h200;
        endcase
    endfunction

    // ---------------- wire monitor ----------------
    logic p_sk = 0, p_cs = 0, p_do = 0;
    int bad_park = 0, bad_do = 0, bad_per = 0, rises = 0;
    int per_cnt = 0; bit per_ok = 0;
    int low_run = 0; int min_gap = 1000000; bit seen_hi = 0;

    always @(negedge clk) if (rst_n) begin
        if (ee_sk && !ee_cs) bad_park++;
        if (ee_sk && p_sk && ee_do != p_do) bad_do++;
        per_cnt++;
        if (!ee_cs) per_ok = 0;
        else if (ee_sk && !p_sk) begin
            rises++;
            if (per_ok && per_cnt != 2 * DIV) bad_per++;
            per_ok = 1; per_cnt = 0;
        end
        if (!ee_cs) low_run++;
        else begin
            if (!p_cs && seen_hi && low_run < min_gap) min_gap = low_run;
            seen_hi = 1; low_run = 0;
        end
        p_sk = ee_sk; p_cs = ee_cs; p_do = ee_do;
    end

    // ---------------- command driver ----------------
    int poke_mode = 0;   // 0 none, 1 start in done cycle, 2 start mid-command

    task automatic run_cmd(input logic [2:0] c, input logic [6:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output logic [1:0] st);
        @(negedge clk);
        start = 1; cmd = c; addr = a; wdata = d;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R11 busy after start", busy, 1);
        if (poke_mode == 2) begin
            repeat (4) @(negedge clk);
            start = 1; cmd = 3'd4; wdata = 8'h00;
            @(negedge clk);
            start = 0;
        end
        while (!done) @(negedge clk);
        rd = rdata; st = status;
        if (poke_mode == 1) begin
            start = 1; cmd = 3'd1; addr = a + 7'd1; wdata = 8'h99;
        end
        @(negedge clk);
        start = 0;
        chk(done == 1'b0, "R11 done single cycle", done, 0);
        while (busy) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] rd;
        logic [1:0] st;
        int fr0;
        repeat (3) @(negedge clk);
        chk(ee_cs == 0, "R1 cs reset", ee_cs, 0);
        chk(ee_sk == 0, "R1 sk reset", ee_sk, 0);
        chk(busy == 0 && done == 0, "R1 busy/done reset", {busy, done}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // write while locked: no busy ever seen
        run_cmd(3'd1, 7'd5, 8'h3C, rd, st);
        chk(st == 2'd1, "R6 locked write status", st, 1);
        run_cmd(3'd0, 7'd5, 8'h00, rd, st);
        chk(rd == (8'd5 ^ 8'hA5), "R6 locked write left cell", rd, 8'd5 ^ 8'hA5);
        chk(last_frame == exp_frame(0, 5), "R2 read frame", last_frame, exp_frame(0, 5));

        run_cmd(3'd5, 7'd0, 8'h00, rd, st);
        chk(st == 2'd0, "R2 unlock status", st, 0);
        chk(last_frame == exp_frame(5, 0), "R2 unlock frame", last_frame, exp_frame(5, 0));

        for (int a = 0; a < 128; a++) begin
            run_cmd(3'd1, 7'(a), 8'((a * 7 + 3) & 255), rd, st);
            chk(st == 2'd0, "R4 write status", st, 0);
            chk(last_frame == exp_frame(1, a), "R2 write frame", last_frame, exp_frame(1, a));
        end
        for (int a = 0; a < 128; a++) begin
            run_cmd(3'd0, 7'(a), 8'h00, rd, st);
            chk(rd == 8'((a * 7 + 3) & 255), "R3 read data", rd, (a * 7 + 3) & 255);
            chk(st == 2'd0, "R3 read status", st, 0);
        end

        run_cmd(3'd2, 7'd10, 8'h00, rd, st);
        chk(st == 2'd0, "R5 erase status", st, 0);
        chk(last_frame == exp_frame(2, 10), "R2 erase frame", last_frame, exp_frame(2, 10));
        run_cmd(3'd0, 7'd10, 8'h00, rd, st);
        chk(rd == 8'hFF, "R5 erased cell", rd, 8'hFF);
        run_cmd(3'd0, 7'd11, 8'h00, rd, st);
        chk(rd == 8'((11 * 7 + 3) & 255), "R5 erase neighbour", rd, (11 * 7 + 3) & 255);

        run_cmd(3'd4, 7'd0, 8'h5A, rd, st);
        chk(st == 2'd0, "R5 write-all status", st, 0);
        chk(last_frame == exp_frame(4, 0), "R2 write-all frame", last_frame, exp_frame(4, 0));
        for (int a = 0; a < 128; a += 63) begin
            run_cmd(3'd0, 7'(a), 8'h00, rd, st);
            chk(rd == 8'h5A, "R5 write-all data", rd, 8'h5A);
        end

        run_cmd(3'd3, 7'd0, 8'h00, rd, st);
        chk(st == 2'd0, "R5 erase-all status", st, 0);
        chk(last_frame == exp_frame(3, 0), "R2 erase-all frame", last_frame, exp_frame(3, 0));
        run_cmd(3'd0, 7'd127, 8'h00, rd, st);
        chk(rd == 8'hFF, "R5 erase-all data", rd, 8'hFF);

        // stray starts during a command and in its done cycle
        fr0 = nframes;
        poke_mode = 1;
        run_cmd(3'd1, 7'd20, 8'h11, rd, st);
        poke_mode = 2;
        run_cmd(3'd1, 7'd22, 8'h33, rd, st);
        poke_mode = 0;
        chk(nframes == fr0 + 2, "R8 stray starts ignored", nframes - fr0, 2);
        run_cmd(3'd0, 7'd21, 8'h00, rd, st);
        chk(rd == 8'hFF, "R8 done-cycle start ignored", rd, 8'hFF);
        run_cmd(3'd0, 7'd23, 8'h00, rd, st);
        chk(rd == 8'hFF, "R8 mid-command start ignored", rd, 8'hFF);
        run_cmd(3'd0, 7'd20, 8'h00, rd, st);
        chk(rd == 8'h11, "R4 write under poke", rd, 8'h11);

        // device stuck busy
        stuck = 1;
        run_cmd(3'd1, 7'd30, 8'h44, rd, st);
        chk(st == 2'd2, "R7 ready timeout", st, 2);
        stuck = 0; busy_cnt = 0;
        repeat (2) @(negedge clk);

        run_cmd(3'd6, 7'd0, 8'h00, rd, st);
        chk(st == 2'd0, "R2 lock status", st, 0);
        chk(last_frame == exp_frame(6, 0), "R2 lock frame", last_frame, exp_frame(6, 0));
        run_cmd(3'd1, 7'd40, 8'h77, rd, st);
        chk(st == 2'd1, "R6 write after lock", st, 1);
        run_cmd(3'd0, 7'd40, 8'h00, rd, st);
        chk(rd == 8'hFF, "R6 cell after lock", rd, 8'hFF);

        run_cmd(3'd5, 7'd0, 8'h00, rd, st);
        run_cmd(3'd7, 7'd0, 8'h00, rd, st);
        chk(last_frame == exp_frame(6, 0), "R2 code 7 frame", last_frame, exp_frame(6, 0));
        run_cmd(3'd1, 7'd41, 8'h12, rd, st);
        chk(st == 2'd1, "R2 code 7 locks", st, 1);

        chk(min_gap >= 2 * DIV, "R9 cs low gap", min_gap, 2 * DIV);
        chk(bad_park == 0, "R10 sk low with cs low", bad_park, 0);
        chk(bad_do == 0, "R10 do steady while sk high", bad_do, 0);
        chk(bad_per == 0 && rises > 0, "R10 sk period", bad_per, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule